// File: doc/BRIEF.md
# Multi-Lane Serial Flash Read Engine

This block is the host side of a serial flash link, used for read traffic only. A caller hands it one request made of a read-kind selector, a 24-bit start address and a byte count. The block then selects the flash and drives its serial clock. It sends the command byte and the address, then any mode byte and idle clocks the selected read kind needs. After that it collects the returned data on two or four lanes and passes the bytes downstream on a valid/ready stream, one at a time.

The lane count can change from one phase of a transfer to the next. The command byte always travels on a single lane. The address and mode byte use one, two or four lanes, and the data uses two or four. For the four-lane kinds, the two pins that otherwise act as write-protect and hold become data lanes 2 and 3. For the two-lane kinds they are held high, so neither function is active. A four-lane request is turned away with a one-cycle error pulse unless the quad-enable input is set. The clock idle level follows a polarity input, so both the low-idle and high-idle clock modes are supported. If the downstream side stalls, the serial clock pauses at a byte boundary.

Top module: `qspi_rd_ctrl`

## Requirements
- R1: While reset is asserted and in idle, `spi_cs_n` is 1, `spi_sck` equals `cfg_cpol`, `io_oe` is 0, `rd_valid` is 0, and (once idle) `req_ready` is 1.
- R2: The `req_op` encoding is 0 = dual-output read (command 0x3B), 1 = dual address/data read (0xBB), 2 = quad-output read (0x6B), 3 = quad address/data read (0xEB). The command byte is shifted out on lane 0, most significant bit first, over 8 clocks.
- R3: The 24-bit address follows the command, most significant bits first. It uses 1 lane for codes 0 and 2, 2 lanes for code 1 and 4 lanes for code 3. On each clock the highest-numbered lane carries the highest bit.
- R4: Codes 1 and 3 send the byte `MODE_BYTE` (default 0x00) on the address lanes right after the address. Code 3 then has 4 idle clocks, codes 0 and 2 have 8 idle clocks after the address, and code 1 has none.
- R5: Data is taken on 2 lanes for codes 0 and 1 and on 4 lanes for codes 2 and 3. Each byte is assembled most significant bits first, with IO1 (dual) or IO3 (quad) holding the top bit of each group. Bytes come out in rising address order, wrapping at 24 bits.
- R6: A request with code 2 or 3 while `cfg_qe` is 0 is accepted and refused. `err_quad` is 1 for exactly one cycle, `spi_cs_n` stays 1 and no byte is produced.
- R7: Each serial clock is one system cycle low followed by one system cycle high, and the flash samples on the rising edge. `spi_sck` sits at the `cfg_cpol` level for at least one system cycle after `spi_cs_n` falls and before it rises.
- R8: The controller stops driving lanes 0 and 1 (and lanes 2 and 3 for quad codes) from the first idle clock, or from the first data clock when there are no idle clocks, until the select ends. For codes 0 and 1, lanes 2 and 3 are driven high for the whole select.
- R9: While `rd_valid` is 1 and `rd_ready` is 0, `rd_data` holds steady. A new byte is not clocked in until the pending byte is taken, so no byte is lost.
- R10: Exactly `req_len` bytes are delivered. `spi_cs_n` rises only after the last byte has been accepted downstream, and `req_ready` is 0 for the whole transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cpol | input | 1 | Serial clock idle level (0 low, 1 high) |
| cfg_qe | input | 1 | Flash quad mode is enabled |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Controller idle, request taken |
| req_op | input | 2 | Read kind selector (see R2) |
| req_addr | input | 24 | Start byte address |
| req_len | input | LEN_W | Byte count, nonzero |
| err_quad | output | 1 | One-cycle pulse on a refused quad request |
| rd_valid | output | 1 | Read byte available |
| rd_ready | input | 1 | Downstream takes the byte |
| rd_data | output | 8 | Read byte |
| spi_cs_n | output | 1 | Flash select, active low |
| spi_sck | output | 1 | Serial clock |
| io_out | output | 4 | Lane output values |
| io_oe | output | 4 | Lane output enables |
| io_in | input | 4 | Lane input values |

## Verification
The assertions assume that `req_len` is never zero and that `cfg_cpol` and `cfg_qe` stay fixed while a transfer is in progress. They also assume the flash model changes `io_in` only on serial clock falling edges. The stimulus changes the configuration only between transfers, while `req_ready` is high. The flash model in the bench drives its lanes from the falling clock edges it sees. Downstream backpressure is applied as a fixed duty pattern on `rd_ready`, driven away from the sampling edge.

// File: rtl/qspi_rd_pkg.sv
package qspi_rd_pkg;

  typedef enum logic [1:0] {
    OP_DOUT = 2'd0,
    OP_DIO  = 2'd1,
    OP_QOUT = 2'd2,
    OP_QIO  = 2'd3
  } rd_op_e;

  typedef enum logic [2:0] {
    PH_IDLE, PH_LEAD, PH_CMD, PH_ADDR, PH_MODE, PH_DUMMY, PH_DATA, PH_TAIL
  } phase_e;

  function automatic logic [7:0] op_code(rd_op_e op);
    case (op)
      OP_DOUT: return 8'h3B;
      OP_DIO:  return 8'hBB;
      OP_QOUT: return 8'h6B;
      default: return 8'hEB;
    endcase
  endfunction

  function automatic logic is_quad(rd_op_e op);
    return (op == OP_QOUT) || (op == OP_QIO);
  endfunction

  function automatic logic has_mode(rd_op_e op);
    return (op == OP_DIO) || (op == OP_QIO);
  endfunction

  function automatic logic [2:0] addr_lanes(rd_op_e op);
    case (op)
      OP_DIO:  return 3'd2;
      OP_QIO:  return 3'd4;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [2:0] data_lanes(rd_op_e op);
    return is_quad(op) ? 3'd4 : 3'd2;
  endfunction

endpackage

// File: rtl/qspi_rd_seq.sv
module qspi_rd_seq
  import qspi_rd_pkg::*;
#(
  parameter int          LEN_W     = 16,
  parameter int          ADDR_W    = 24,
  parameter logic [7:0]  MODE_BYTE = 8'h00,
  parameter int          DUMMY_OUT = 8,
  parameter int          DUMMY_QIO = 4
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              req_valid,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              cfg_qe,
  input  logic              rd_valid,
  input  logic              rd_ready,
  output logic              req_ready,
  output logic              err_quad,
  output phase_e            ph,
  output rd_op_e            op,
  output logic [3:0]        sr_top,
  output logic [2:0]        cur_w,
  output logic              half,
  output logic              sample,
  output logic              byte_done
);
  localparam int SR_W  = 8 + ADDR_W;
  localparam int M1    = (ADDR_W > DUMMY_OUT) ? ADDR_W : DUMMY_OUT;
  localparam int M2    = (M1 > DUMMY_QIO) ? M1 : DUMMY_QIO;
  localparam int CNT_W = $clog2(M2 + 1);

  phase_e             ph_q, ph_d;
  rd_op_e             op_q, op_d;
  logic [SR_W-1:0]    sr_q, sr_d;
  logic               half_q, half_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [LEN_W-1:0]   bytes_q, bytes_d;
  logic               err_q, err_d;
  logic               stall;
  logic [CNT_W-1:0]   byte_last;

  function automatic logic [CNT_W-1:0] clk_last(input int unsigned bits, input logic [2:0] w);
    int unsigned n;
    n = (w == 3'd4) ? bits / 4 : (w == 3'd2) ? bits / 2 : bits;
    return CNT_W'(n - 1);
  endfunction

  function automatic int unsigned dummy_clks(input rd_op_e o);
    case (o)
      OP_DOUT, OP_QOUT: return unsigned'(DUMMY_OUT);
      OP_QIO:           return unsigned'(DUMMY_QIO);
      default:          return 0;
    endcase
  endfunction

  always_comb begin
    case (ph_q)
      PH_ADDR, PH_MODE: cur_w = addr_lanes(op_q);
      PH_DATA:          cur_w = data_lanes(op_q);
      default:          cur_w = 3'd1;
    endcase
  end

  assign byte_last = clk_last(8, data_lanes(op_q));
  assign stall     = (ph_q == PH_DATA) && !half_q && (cnt_q == byte_last) && rd_valid && !rd_ready;
  assign sample    = (ph_q == PH_DATA) && !half_q && !stall;
  assign byte_done = sample && (cnt_q == '0);

  // next-state logic
  always_comb begin
    ph_d    = ph_q;
    op_d    = op_q;
    sr_d    = sr_q;
    half_d  = half_q;
    cnt_d   = cnt_q;
    bytes_d = bytes_q;
    err_d   = 1'b0;
    case (ph_q)
      PH_IDLE: begin
        if (req_valid) begin
          if (is_quad(rd_op_e'(req_op)) && !cfg_qe) begin
            err_d = 1'b1;
          end else begin
            ph_d    = PH_LEAD;
            op_d    = rd_op_e'(req_op);
            sr_d    = {op_code(rd_op_e'(req_op)), req_addr};
            bytes_d = req_len;
          end
        end
      end
      PH_LEAD: begin
        ph_d   = PH_CMD;
        cnt_d  = CNT_W'(7);
        half_d = 1'b0;
      end
      PH_TAIL: begin
        if (!rd_valid) ph_d = PH_IDLE;
      end
      default: begin
        if (!stall) begin
          half_d = ~half_q;
          if (half_q) begin
            sr_d = sr_q << cur_w;
            if (cnt_q != '0) begin
              cnt_d = cnt_q - 1'b1;
            end else begin
              case (ph_q)
                PH_CMD: begin
                  ph_d  = PH_ADDR;
                  cnt_d = clk_last(ADDR_W, addr_lanes(op_q));
                end
                PH_ADDR: begin
                  if (has_mode(op_q)) begin
                    ph_d  = PH_MODE;
                    cnt_d = clk_last(8, addr_lanes(op_q));
                    sr_d  = {MODE_BYTE, {ADDR_W{1'b0}}};
                  end else if (dummy_clks(op_q) != 0) begin
                    ph_d  = PH_DUMMY;
                    cnt_d = CNT_W'(dummy_clks(op_q) - 1);
                  end else begin
                    ph_d  = PH_DATA;
                    cnt_d = byte_last;
                  end
                end
                PH_MODE: begin
                  if (dummy_clks(op_q) != 0) begin
                    ph_d  = PH_DUMMY;
                    cnt_d = CNT_W'(dummy_clks(op_q) - 1);
                  end else begin
                    ph_d  = PH_DATA;
                    cnt_d = byte_last;
                  end
                end
                PH_DUMMY: begin
                  ph_d  = PH_DATA;
                  cnt_d = byte_last;
                end
                default: begin
                  bytes_d = bytes_q - 1'b1;
                  cnt_d   = byte_last;
                  if (bytes_q == LEN_W'(1)) ph_d = PH_TAIL;
                end
              endcase
            end
          end
        end
      end
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q    <= PH_IDLE;
      op_q    <= OP_DOUT;
      sr_q    <= '0;
      half_q  <= 1'b0;
      cnt_q   <= '0;
      bytes_q <= '0;
      err_q   <= 1'b0;
    end else begin
      ph_q    <= ph_d;
      op_q    <= op_d;
      sr_q    <= sr_d;
      half_q  <= half_d;
      cnt_q   <= cnt_d;
      bytes_q <= bytes_d;
      err_q   <= err_d;
    end
  end

  assign req_ready = (ph_q == PH_IDLE);
  assign err_quad  = err_q;
  assign ph        = ph_q;
  assign op        = op_q;
  assign sr_top    = sr_q[SR_W-1 -: 4];
  assign half      = half_q;

  // R6
  quad_refuse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (req_valid && req_ready && req_op[1] && !cfg_qe) |=> (err_quad && ph_q == PH_IDLE));

  // R6
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    err_quad |=> !err_quad);

  // R10
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    req_ready |-> !rd_valid);

endmodule

// File: rtl/qspi_rd_txmap.sv
module qspi_rd_txmap
  import qspi_rd_pkg::*;
(
  input  phase_e     ph,
  input  rd_op_e     op,
  input  logic [3:0] sr_top,
  input  logic [2:0] cur_w,
  output logic [3:0] io_out,
  output logic [3:0] io_oe
);
  always_comb begin
    io_out = 4'b0000;
    io_oe  = 4'b0000;
    if (ph == PH_CMD || ph == PH_ADDR || ph == PH_MODE) begin
      case (cur_w)
        3'd4: begin
          io_out = sr_top;
          io_oe  = 4'b1111;
        end
        3'd2: begin
          io_out[1:0] = sr_top[3:2];
          io_oe[1:0]  = 2'b11;
        end
        default: begin
          io_out[0] = sr_top[3];
          io_oe[0]  = 1'b1;
        end
      endcase
    end
    if (ph != PH_IDLE && !is_quad(op)) begin
      io_out[3:2] = 2'b11;
      io_oe[3:2]  = 2'b11;
    end
  end
endmodule

// File: rtl/qspi_rd_rx.sv
module qspi_rd_rx (
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       sample,
  input  logic       byte_done,
  input  logic [2:0] width,
  input  logic [3:0] io_in,
  input  logic       rd_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data
);
  logic [7:0] acc_q, acc_d;
  logic [7:0] data_q, data_d;
  logic       vld_q, vld_d;

  always_comb begin
    acc_d  = acc_q;
    data_d = data_q;
    vld_d  = vld_q;
    if (sample) acc_d = (width == 3'd4) ? {acc_q[3:0], io_in} : {acc_q[5:0], io_in[1:0]};
    if (byte_done) begin
      data_d = acc_d;
      vld_d  = 1'b1;
    end else if (vld_q && rd_ready) begin
      vld_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      data_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      data_q <= data_d;
      vld_q  <= vld_d;
    end
  end

  assign rd_valid = vld_q;
  assign rd_data  = data_q;

  // R9
  hold_data_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_data)));

endmodule

// File: rtl/qspi_rd_ctrl.sv
module qspi_rd_ctrl
  import qspi_rd_pkg::*;
#(
  parameter int         LEN_W     = 16,
  parameter int         ADDR_W    = 24,
  parameter logic [7:0] MODE_BYTE = 8'h00,
  parameter int         DUMMY_OUT = 8,
  parameter int         DUMMY_QIO = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_cpol,
  input  logic              cfg_qe,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  output logic              err_quad,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [7:0]        rd_data,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe,
  input  logic [3:0]        io_in
);
  logic [1:0] rs_q;
  logic       rst_ni;
  phase_e     ph;
  rd_op_e     op;
  logic [3:0] sr_top;
  logic [2:0] cur_w;
  logic       half, sample, byte_done;

  // reset: asserted asynchronously, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  qspi_rd_seq #(
    .LEN_W(LEN_W), .ADDR_W(ADDR_W), .MODE_BYTE(MODE_BYTE),
    .DUMMY_OUT(DUMMY_OUT), .DUMMY_QIO(DUMMY_QIO)
  ) seq_i (
    .clk(clk), .rst_ni(rst_ni), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .cfg_qe(cfg_qe),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .req_ready(req_ready),
    .err_quad(err_quad), .ph(ph), .op(op), .sr_top(sr_top), .cur_w(cur_w),
    .half(half), .sample(sample), .byte_done(byte_done)
  );

  qspi_rd_txmap tx_i (
    .ph(ph), .op(op), .sr_top(sr_top), .cur_w(cur_w),
    .io_out(io_out), .io_oe(io_oe)
  );

  qspi_rd_rx rx_i (
    .clk(clk), .rst_ni(rst_ni), .sample(sample), .byte_done(byte_done),
    .width(cur_w), .io_in(io_in), .rd_ready(rd_ready),
    .rd_valid(rd_valid), .rd_data(rd_data)
  );

  assign spi_cs_n = (ph == PH_IDLE);
  assign spi_sck  = (ph == PH_LEAD || ph == PH_TAIL || ph == PH_IDLE) ? cfg_cpol : half;

  // R7
  cs_fall_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $fell(spi_cs_n) |-> (spi_sck == cfg_cpol));

  // R7
  cs_rise_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(spi_cs_n) |-> ($past(spi_sck) == cfg_cpol));

  // R8
  rx_released_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    rd_valid |-> (io_oe[1:0] == 2'b00));

endmodule

// File: tb/qspi_rd_ctrl_tb.sv
`timescale 1ns/1ps
module qspi_rd_ctrl_tb_top;
  localparam int LEN_W = 16;
  localparam logic [7:0] MODE_B = 8'h00;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic cfg_cpol = 1'b0, cfg_qe = 1'b1;
  logic req_valid = 1'b0, rd_ready = 1'b1;
  logic [1:0] req_op = 2'd0;
  logic [23:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [3:0] io_in = 4'h0;
  logic req_ready, err_quad, rd_valid, spi_cs_n, spi_sck;
  logic [7:0] rd_data;
  logic [3:0] io_out, io_oe;

  qspi_rd_ctrl #(.LEN_W(LEN_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_qe(cfg_qe),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_len(req_len), .err_quad(err_quad),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .spi_cs_n(spi_cs_n), .spi_sck(spi_sck), .io_out(io_out), .io_oe(io_oe),
    .io_in(io_in)
  );

  int checks = 0, fails = 0;
  int cyc = 0;
  bit bp = 0, tx_on = 0, done = 0;
  logic [7:0] exp_op;
  logic [23:0] exp_addr;
  int exp_len = 0, rx_cnt = 0;
  logic [1:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ 8'hA5;
  endfunction
  function automatic logic [7:0] f_code(input logic [1:0] o);
    case (o) 2'd0: return 8'h3B; 2'd1: return 8'hBB; 2'd2: return 8'h6B; default: return 8'hEB; endcase
  endfunction
  function automatic int f_aw(input logic [7:0] c);
    return (c == 8'hBB) ? 2 : (c == 8'hEB) ? 4 : 1;
  endfunction
  function automatic int f_dw(input logic [7:0] c);
    return (c == 8'h6B || c == 8'hEB) ? 4 : 2;
  endfunction
  function automatic bit f_mode(input logic [7:0] c);
    return (c == 8'hBB || c == 8'hEB);
  endfunction
  function automatic bit f_quad(input logic [7:0] c);
    return (c == 8'h6B || c == 8'hEB);
  endfunction
  function automatic int f_dum(input logic [7:0] c);
    return (c == 8'h3B || c == 8'h6B) ? 8 : (c == 8'hEB) ? 4 : 0;
  endfunction
  function automatic int f_hdr(input logic [7:0] c);
    return 8 + 24 / f_aw(c) + (f_mode(c) ? 8 / f_aw(c) : 0) + f_dum(c);
  endfunction

  // flash device model
  int m_clk = 0;
  logic [7:0] m_op = '0, m_mode = '0;
  logic [23:0] m_addr = '0;

  always @(negedge spi_cs_n) begin
    m_clk = 0; m_op = '0; m_mode = '0; m_addr = '0;
    if (!tx_on) chk(1'b0, "R6 select on refused request", {31'd0, spi_cs_n}, 32'd1);
  end

  always @(posedge spi_sck) begin
    int a;
    if (!spi_cs_n) begin
      a = f_aw(m_op);
      if (m_clk < 8) m_op = {m_op[6:0], io_out[0]};
      else if (m_clk < 8 + 24 / a) begin
        if (a == 4) m_addr = {m_addr[19:0], io_out};
        else if (a == 2) m_addr = {m_addr[21:0], io_out[1:0]};
        else m_addr = {m_addr[22:0], io_out[0]};
      end else if (f_mode(m_op) && m_clk < 8 + 24 / a + 8 / a) begin
        if (a == 4) m_mode = {m_mode[3:0], io_out};
        else m_mode = {m_mode[5:0], io_out[1:0]};
      end else if (m_clk >= f_hdr(m_op)) begin
        chk(io_oe[1:0] == 2'b00 && (!f_quad(m_op) || io_oe[3:2] == 2'b00),
            "R8 lanes released in data", {28'd0, io_oe}, 32'd0);
      end
      if (m_clk >= 8 && !f_quad(m_op))
        chk(io_oe[3:2] == 2'b11 && io_out[3:2] == 2'b11, "R8 protect/hold high",
            {28'd0, io_oe[3:2], io_out[3:2]}, 32'hF);
      m_clk++;
    end
  end

  always @(negedge spi_sck) begin
    int d, cpb, idx, pos;
    logic [7:0] b;
    if (!spi_cs_n && m_clk >= 8 && m_clk >= f_hdr(m_op)) begin
      d = m_clk - f_hdr(m_op);
      cpb = 8 / f_dw(m_op);
      idx = d / cpb;
      pos = d % cpb;
      b = mem_byte(24'(m_addr + 24'(idx)));
      if (f_dw(m_op) == 4) io_in = (pos == 0) ? b[7:4] : b[3:0];
      else io_in = {2'b00, b[7-2*pos -: 2]};
    end
  end

  always @(posedge spi_cs_n) begin
    if (tx_on && !done) begin
      chk(m_op == exp_op, "R2 command byte", {24'd0, m_op}, {24'd0, exp_op});
      chk(m_addr == exp_addr, "R3 address", {8'd0, m_addr}, {8'd0, exp_addr});
      if (f_mode(exp_op)) chk(m_mode == MODE_B, "R4 mode byte", {24'd0, m_mode}, {24'd0, MODE_B});
      chk(m_clk == f_hdr(exp_op) + exp_len * (8 / f_dw(exp_op)), "R4 clock count",
          m_clk, f_hdr(exp_op) + exp_len * (8 / f_dw(exp_op)));
      chk(rx_cnt == exp_len, "R10 bytes before deselect", rx_cnt, exp_len);
      done = 1;
    end
  end

  // per-cycle reference for select and clock, and data stream check
  always @(negedge clk) begin
    logic [1:0] e;
    if (exp_q.size() > 0) begin
      e = exp_q.pop_front();
      chk({spi_cs_n, spi_sck} == e, "R7 select/clock waveform", {30'd0, spi_cs_n, spi_sck}, {30'd0, e});
    end
    if (rd_valid && rd_ready) begin
      chk(rd_data == mem_byte(24'(exp_addr + 24'(rx_cnt))), "R5 data byte",
          {24'd0, rd_data}, {24'd0, mem_byte(24'(exp_addr + 24'(rx_cnt)))});
      rx_cnt++;
    end
  end

  logic [7:0] held_d;
  bit held_v = 0;
  always @(negedge clk) begin
    if (held_v && rd_valid) chk(rd_data == held_d, "R9 data held under stall", {24'd0, rd_data}, {24'd0, held_d});
    held_v = rd_valid && !rd_ready;
    held_d = rd_data;
  end

  always @(posedge clk) begin
    cyc++;
    #1 rd_ready = bp ? (cyc % 3 == 0) : 1'b1;
  end

  always @(posedge clk) begin
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic run_rd(input logic [1:0] op, input logic [23:0] addr, input int len,
                        input bit cpol, input bit bpr);
    int tot;
    @(negedge clk);
    cfg_cpol = cpol; cfg_qe = 1'b1; bp = bpr;
    exp_op = f_code(op); exp_addr = addr; exp_len = len; rx_cnt = 0; tx_on = 1; done = 0;
    req_op = op; req_addr = addr; req_len = LEN_W'(len); req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    if (!bpr) begin
      tot = f_hdr(exp_op) + len * (8 / f_dw(exp_op));
      exp_q.push_back({1'b0, cpol});
      for (int i = 0; i < tot; i++) begin
        exp_q.push_back(2'b00);
        exp_q.push_back(2'b01);
      end
      exp_q.push_back({1'b0, cpol});
      exp_q.push_back({1'b1, cpol});
    end
    @(negedge clk);
    chk(!req_ready, "R10 busy during transfer", {31'd0, req_ready}, 32'd0);
    wait (done);
    repeat (3) @(negedge clk);
    chk(req_ready && spi_cs_n && !rd_valid, "R10 idle after transfer",
        {29'd0, req_ready, spi_cs_n, rd_valid}, 32'h6);
    bp = 0;
  endtask

  task automatic run_refuse(input logic [1:0] op);
    @(negedge clk);
    cfg_qe = 1'b0; tx_on = 0; rx_cnt = 0;
    req_op = op; req_addr = 24'h000100; req_len = LEN_W'(2); req_valid = 1'b1;
    @(posedge clk);
    #1 req_valid = 1'b0;
    @(negedge clk);
    chk(err_quad == 1'b1, "R6 error pulse", {31'd0, err_quad}, 32'd1);
    chk(spi_cs_n == 1'b1, "R6 no select", {31'd0, spi_cs_n}, 32'd1);
    @(negedge clk);
    chk(err_quad == 1'b0, "R6 pulse one cycle", {31'd0, err_quad}, 32'd0);
    repeat (20) @(negedge clk);
    chk(spi_cs_n && req_ready && rx_cnt == 0, "R6 no bytes produced", rx_cnt, 32'd0);
    cfg_qe = 1'b1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == cfg_cpol, "R1 reset select/clock",
        {30'd0, spi_cs_n, spi_sck}, {30'd0, 1'b1, cfg_cpol});
    chk(io_oe == 4'h0 && !rd_valid, "R1 reset lanes/valid", {27'd0, rd_valid, io_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(req_ready == 1'b1, "R1 ready after reset", {31'd0, req_ready}, 32'd1);

    run_rd(2'd0, 24'h123456, 3, 1'b0, 1'b0);
    run_rd(2'd1, 24'hABCDEF, 4, 1'b1, 1'b0);
    run_rd(2'd2, 24'hFFFFFE, 5, 1'b0, 1'b0);
    run_rd(2'd3, 24'h7A5A10, 2, 1'b1, 1'b0);
    run_rd(2'd1, 24'h000001, 1, 1'b0, 1'b0);
    run_refuse(2'd3);
    run_refuse(2'd2);
    run_rd(2'd3, 24'h3C0F00, 6, 1'b0, 1'b1);
    run_rd(2'd0, 24'h00FF80, 5, 1'b1, 1'b1);
    run_rd(2'd2, 24'h55AA33, 3, 1'b1, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule